// File: doc/BRIEF.md
# Three-Wire Divider Programming Loader

This block receives divider settings for a frequency synthesiser over a three-wire serial link made of a data line, a shift clock and a frame enable. The three wires are asynchronous to the fast system clock. They pass through synchronisers, and their edges are detected in the system clock domain. While the enable is high, each falling edge of the shift clock moves one data bit into a shift register and advances an edge counter. The counter stops at the length of a full frame.

The transfer to the output latches happens when the enable falls. The edge count decides what is loaded:
- A full frame of 30 edges loads four fields: the swallow count A (7 bits), the main count M (10 bits), the 2-bit band word and the reference count R (11 bits).
- A short frame of 19 edges refreshes only A, M and the band word, and leaves R as it was.
- Any other count discards the frame.

Every accepted transfer also sends a one-cycle restart pulse, so that the reference and main dividers start again together.

Top module: `synth_prog_loader`

## Requirements
- R1: After reset, A reads 0, M reads 0, the band outputs read 0, R reads 3, and the restart output is low.
- R2: In a full frame, the bits arrive most significant bit first, in this order: A in bits 1 to 7, M in bits 8 to 17, band in bits 18 to 19, and R in bits 20 to 30. A full frame loads all four latches.
- R3: A data bit is taken on the falling edge of the shift clock. The data value seen at the rising edge has no effect.
- R4: While the enable is low, shift clock and data activity changes no output and produces no restart pulse.
- R5: A frame of exactly 19 edges loads A, M and band from bits 1 to 19, in the same positions as in a full frame. R is left unchanged.
- R6: A frame whose edge count is neither 19 nor 30 changes no latch and produces no restart pulse.
- R7: Edges after the thirtieth in a frame are ignored. The frame still loads from its first 30 bits, and the edge count never exceeds 30.
- R8: The edge count restarts from zero each time the enable rises, so an aborted frame does not affect the next frame.
- R9: Each accepted transfer produces exactly one restart pulse, one system clock wide, in the same cycle that the latches take their new values.
- R10: A full frame whose R field is below 3 loads A, M and band but leaves R unchanged, so R always stays at 3 or above.
- R11: The two band outputs are registered copies of the band field of the last accepted frame.
- R12: The latches and the restart pulse change on the third rising edge of the system clock after the falling enable is presented at the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Shift clock, asynchronous; bits are taken on its falling edge |
| ser_en | input | 1 | Frame enable, asynchronous; a transfer happens on its falling edge |
| a_word | output | 7 | Swallow count latch |
| m_word | output | 10 | Main count latch |
| band_out | output | 2 | Band output pins |
| r_word | output | 11 | Reference count latch |
| div_restart | output | 1 | One-cycle pulse that restarts both divider chains |

## Verification
Between frames, nothing inside the block can be seen at the ports: a wrong edge count or wrong shift contents only shows at the next falling enable. At that point, three system clocks after the enable drops, a bad count shows either as a missing or extra restart pulse or as latches that change when they should not. A bad shift register shows as wrong field values in that same cycle. The bench predicts every output in every cycle, so a fault is reported in the exact cycle where it first appears, and not only at the end of a frame.

// File: rtl/synth_prog_loader.sv
module synth_prog_loader #(
  parameter int A_W = 7,
  parameter int M_W = 10,
  parameter int B_W = 2,
  parameter int R_W = 11,
  parameter int R_MIN = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_data,
  input  logic           ser_clk,
  input  logic           ser_en,
  output logic [A_W-1:0] a_word,
  output logic [M_W-1:0] m_word,
  output logic [B_W-1:0] band_out,
  output logic [R_W-1:0] r_word,
  output logic           div_restart
);
  localparam int SHORT = A_W + M_W + B_W;
  localparam int FULL  = SHORT + R_W;
  localparam int CW    = $clog2(FULL + 1);

  logic [SYNC_STAGES-1:0] d_sync, c_sync, e_sync;
  logic                   c_prev, e_prev;
  logic                   d_s, c_s, en_s;
  logic [CW-1:0]          bit_cnt;
  logic [FULL-1:0]        sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_sync <= '0;
      c_sync <= '0;
      e_sync <= '0;
      c_prev <= 1'b0;
      e_prev <= 1'b0;
    end else begin
      d_sync <= {d_sync[SYNC_STAGES-2:0], ser_data};
      c_sync <= {c_sync[SYNC_STAGES-2:0], ser_clk};
      e_sync <= {e_sync[SYNC_STAGES-2:0], ser_en};
      c_prev <= c_s;
      e_prev <= en_s;
    end
  end

  assign d_s  = d_sync[SYNC_STAGES-1];
  assign c_s  = c_sync[SYNC_STAGES-1];
  assign en_s = e_sync[SYNC_STAGES-1];

  wire clk_fall  = c_prev & ~c_s;
  wire en_fall   = e_prev & ~en_s;
  wire en_rise   = ~e_prev & en_s;
  wire take_bit  = en_s & clk_fall & (bit_cnt != CW'(FULL));
  wire full_hit  = en_fall & (bit_cnt == CW'(FULL));
  wire short_hit = en_fall & (bit_cnt == CW'(SHORT));
  wire r_ok      = sh[R_W-1:0] >= R_W'(R_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
    end else begin
      if (en_rise)
        bit_cnt <= '0;
      else if (take_bit)
        bit_cnt <= bit_cnt + 1'b1;
      if (take_bit)
        sh <= {sh[FULL-2:0], d_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_word      <= '0;
      m_word      <= '0;
      band_out    <= '0;
      r_word      <= R_W'(R_MIN);
      div_restart <= 1'b0;
    end else begin
      div_restart <= full_hit | short_hit;
      if (full_hit) begin
        a_word   <= sh[FULL-1 -: A_W];
        m_word   <= sh[FULL-1-A_W -: M_W];
        band_out <= sh[R_W +: B_W];
        if (r_ok)
          r_word <= sh[R_W-1:0];
      end else if (short_hit) begin
        a_word   <= sh[SHORT-1 -: A_W];
        m_word   <= sh[B_W +: M_W];
        band_out <= sh[B_W-1:0];
      end
    end
  end
endmodule

// File: rtl/prog_loader_chk.sv
module prog_loader_chk #(
  parameter int A_W = 7,
  parameter int M_W = 10,
  parameter int B_W = 2,
  parameter int R_W = 11,
  parameter int R_MIN = 3,
  parameter int CW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_s,
  input logic [CW-1:0]  cnt,
  input logic [A_W-1:0] a_word,
  input logic [M_W-1:0] m_word,
  input logic [B_W-1:0] band_out,
  input logic [R_W-1:0] r_word,
  input logic           div_restart
);
  localparam int FULL = A_W + M_W + B_W + R_W;

  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FULL));

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_restart |=> !div_restart);

  p_r_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    r_word >= R_W'(R_MIN));

  p_r_moves_on_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r_word) |-> div_restart);

  p_fields_move_on_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({a_word, m_word, band_out}) |-> div_restart);

  p_idle_holds_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> $stable(cnt));
endmodule

bind synth_prog_loader prog_loader_chk #(
  .A_W(A_W), .M_W(M_W), .B_W(B_W), .R_W(R_W), .R_MIN(R_MIN), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .cnt(bit_cnt),
  .a_word(a_word), .m_word(m_word), .band_out(band_out),
  .r_word(r_word), .div_restart(div_restart)
);

// File: tb/synth_prog_loader_tb.sv
module synth_prog_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ser_data = 0, ser_clk = 0, ser_en = 0;
  logic [6:0]  a_word;
  logic [9:0]  m_word;
  logic [1:0]  band_out;
  logic [10:0] r_word;
  logic        div_restart;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_en(ser_en), .a_word(a_word), .m_word(m_word), .band_out(band_out),
    .r_word(r_word), .div_restart(div_restart)
  );

  // behavioural reference: three-deep input history, bit queue, counter
  logic h1d, h2d, h1c, h2c, h3c, h1e, h2e, h3e;
  int   mcnt;
  bit   mbits[$];
  int   ma, mm, mb, mr;
  bit   mpulse;

  function automatic int pick(int start, int len);
    int v = 0;
    for (int i = 0; i < len; i++) v = (v << 1) | int'(mbits[start + i]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {h1d, h2d, h1c, h2c, h3c, h1e, h2e, h3e} = '0;
      mcnt = 0; mbits.delete();
      ma = 0; mm = 0; mb = 0; mr = 3; mpulse = 0;
    end else begin
      mpulse = 0;
      if (!h3e && h2e) begin
        mcnt = 0; mbits.delete();
      end else if (h3e && !h2e) begin
        if (mcnt == 30 || mcnt == 19) begin
          ma = pick(0, 7); mm = pick(7, 10); mb = pick(17, 2);
          if (mcnt == 30 && pick(19, 11) >= 3) mr = pick(19, 11);
          mpulse = 1;
        end
      end else if (h2e && h3c && !h2c && mcnt < 30) begin
        mbits.push_back(h2d); mcnt++;
      end
      h2d = h1d; h1d = ser_data;
      h3c = h2c; h2c = h1c; h1c = ser_clk;
      h3e = h2e; h2e = h1e; h1e = ser_en;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (div_restart) pulses++;
      chk("R12 a_word cycle", int'(a_word), ma);
      chk("R12 m_word cycle", int'(m_word), mm);
      chk("R11 band cycle", int'(band_out), mb);
      chk("R10 r_word cycle", int'(r_word), mr);
      chk("R9 restart cycle", int'(div_restart), int'(mpulse));
    end
  end

  task automatic send(input logic [34:0] w, input int n, input bit drop);
    @(negedge clk); ser_en = 1; repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = ~w[i]; repeat (3) @(negedge clk);
      ser_clk = 1; repeat (2) @(negedge clk);
      ser_data = w[i]; repeat (3) @(negedge clk);
      ser_clk = 0; repeat (3) @(negedge clk);
    end
    if (drop) begin
      ser_en = 0; repeat (6) @(negedge clk);
    end
  endtask

  task automatic expect_all(string tag, int a, int m, int b, int r);
    chk({tag, " a_word"}, int'(a_word), a);
    chk({tag, " m_word"}, int'(m_word), m);
    chk({tag, " band_out"}, int'(band_out), b);
    chk({tag, " r_word"}, int'(r_word), r);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_all("R1 reset", 0, 0, 0, 3);
    chk("R1 reset restart", int'(div_restart), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 R3 R12: full frame, exact latency of the update
    send({5'b0, 7'd85, 10'd343, 2'b10, 11'd400}, 30, 0);
    ser_en = 0;
    @(negedge clk); @(negedge clk);
    chk("R12 no update yet", int'(a_word), 0);
    chk("R12 no pulse yet", int'(div_restart), 0);
    @(negedge clk);
    chk("R12 update on third edge", int'(a_word), 85);
    chk("R9 pulse with update", int'(div_restart), 1);
    repeat (4) @(negedge clk);
    expect_all("R2 R3 full frame", 85, 343, 2, 400);
    chk("R11 band copy", int'(band_out), 2);

    // R4: activity with enable low
    for (int k = 0; k < 4; k++) begin
      ser_data = k[0]; ser_clk = 1; repeat (4) @(negedge clk);
      ser_clk = 0; repeat (4) @(negedge clk);
    end
    expect_all("R4 idle activity", 85, 343, 2, 400);
    chk("R4 no pulse", pulses, 1);

    // R5: short frame
    send({16'b0, 7'd48, 10'd700, 2'b01}, 19, 1);
    expect_all("R5 short frame", 48, 700, 1, 400);

    // R6: 12-edge and 29-edge aborts
    send({23'b0, 12'hFFF}, 12, 1);
    expect_all("R6 abort 12", 48, 700, 1, 400);
    send({5'b0, 7'd5, 10'd6, 2'b11, 11'd9} >> 1, 29, 1);
    expect_all("R6 abort 29", 48, 700, 1, 400);
    chk("R6 no pulse", pulses, 2);

    // R7: 35 edges, first 30 used
    send({7'd3, 10'd1023, 2'b11, 11'd2047, 5'b11111}, 35, 1);
    expect_all("R7 extra edges", 3, 1023, 3, 2047);

    // R10: R field below minimum
    send({5'b0, 7'd10, 10'd20, 2'b00, 11'd2}, 30, 1);
    expect_all("R10 low R", 10, 20, 0, 2047);

    // R8: aborted 25-edge frame then a short frame
    send({10'b0, 25'h1ABCDEF}, 25, 1);
    expect_all("R8 abort 25", 10, 20, 0, 2047);
    send({16'b0, 7'd1, 10'd8, 2'b10}, 19, 1);
    expect_all("R8 after abort", 1, 8, 2, 2047);

    chk("R9 pulse count", pulses, 5);
    summary();
  end
endmodule